// File: doc/BRIEF.md
# Vector Multiply-Add Element Sequencer

This block walks through the elements of one vector multiply-add over a small internal file of XLEN-bit registers. For every element it forms the unsigned product of two operand registers, adds a third, and keeps the exact double-width sum. The low half goes to a destination register, and the high half goes to a second destination whose location a one-bit mode selects. In one mode the high half returns to the addend register. With a scalar addend this builds a carry chain from element to element, and with a vector addend it acts as a per-element accumulator. In the other mode the high half lands in a block placed VL registers above the low destination, so the addend is never overwritten.

A command is given with one start strobe. It carries four base register numbers, a scalar/vector flag for each operand, the mode bit and the element count. The block reports `busy` while elements execute and pulses `done` once when the command is complete. A combinational debug port reads any register at any time. The register file comes out of reset with a fixed pattern, so commands have known data to work on without any load path.

Top module: `vmadd_engine`

## Requirements
- R1: After reset `busy` and `done` are low, and register i holds the bitwise inverse of the low XLEN bits of i * 0x9E3779B97F4A7C15. Register 0 therefore holds all ones.
- R2: Each element computes {hi, lo} = A*B + C as an exact unsigned 2*XLEN-bit value. With XLEN=64 and all three operands at all ones, hi is all ones and lo is zero.
- R3: An element writes lo to its RT register and hi to its RS register in the same cycle. If both name the same register, hi is the value kept.
- R4: An operand flagged vector uses register base + element index, and an operand flagged scalar stays at its base. All register numbers wrap modulo the register count.
- R5: With `hi_to_addend`=0, the RS base is RT base + VL (mod register count) and RS follows RT's vector flag. A register that is only an addend and is not a destination keeps its value.
- R6: With `hi_to_addend`=1 and the addend scalar, RS is the addend register, so element i+1 reads as C the hi half written by element i.
- R7: With `hi_to_addend`=1 and the addend vector, each element overwrites its own addend register with its hi half.
- R8: A start accepted at a clock edge gives `busy` high for exactly VL cycles, with element i written at the (i+1)-th edge after acceptance. `done` is high for exactly the one cycle after `busy` falls. VL=0 gives a `done` pulse in the next cycle with no writes. Elements run in ascending order, and both writes of an element land before the next element reads.
- R9: A start while `busy` is high is ignored and does not change the running command.
- R10: `dbg_data` always shows the current content of register `dbg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Command strobe, accepted when not busy |
| src_a | input | RIDX_W | Base register of multiplicand A |
| src_b | input | RIDX_W | Base register of multiplier B |
| src_c | input | RIDX_W | Base register of addend C |
| dst_lo | input | RIDX_W | Base register RT for low halves |
| vec_a | input | 1 | A steps with the element index |
| vec_b | input | 1 | B steps with the element index |
| vec_c | input | 1 | C steps with the element index |
| vec_lo | input | 1 | RT steps with the element index |
| hi_to_addend | input | 1 | 1: RS is the addend register; 0: RS is RT + VL |
| vl | input | VL_W | Element count |
| busy | output | 1 | Elements executing |
| done | output | 1 | One-cycle completion pulse |
| dbg_addr | input | RIDX_W | Debug read register number |
| dbg_data | output | XLEN | Debug read data |

## Verification
The bench builds the block with XLEN=64, sixteen registers, a 5-bit element count and the split partial-product multiplier. With sixteen registers, an RS block placed at RT+VL wraps past the top of the file within a short command, and accumulator runs wrap around the file as well. The full 64-bit width keeps the all-ones worst case in reach, where the high half reaches all ones and the low half is exactly zero. The element counts span zero, one and several elements, so the empty command, the scalar default and the chained carry are each covered.

// File: rtl/vmadd_pkg.sv
package vmadd_pkg;

   // destination choice for the high half of each element
   typedef enum logic {
      HI_ABOVE_RT    = 1'b0,
      HI_INTO_ADDEND = 1'b1
   } hi_dest_e;

   // per-operand scalar(0)/vector(1) selection
   typedef struct packed {
      logic a;
      logic b;
      logic c;
      logic t;
   } vec_flags_t;

   localparam logic [63:0] SEED_MULT = 64'h9E37_79B9_7F4A_7C15;

endpackage

// File: rtl/vmadd_mul.sv
module vmadd_mul #(
   parameter int XLEN  = 64,
   parameter bit SPLIT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic [XLEN-1:0] c_i,
   output logic [XLEN-1:0] hi_o,
   output logic [XLEN-1:0] lo_o
);
   localparam int W2 = 2 * XLEN;
   localparam int H  = XLEN / 2;

   logic [W2-1:0] prod;
   logic [W2-1:0] sum;

   generate
      if (SPLIT) begin : g_split
         logic [W2-1:0] pp_ll, pp_lh, pp_hl, pp_hh;
         assign pp_ll = W2'(a_i[H-1:0])    * W2'(b_i[H-1:0]);
         assign pp_lh = W2'(a_i[H-1:0])    * W2'(b_i[XLEN-1:H]);
         assign pp_hl = W2'(a_i[XLEN-1:H]) * W2'(b_i[H-1:0]);
         assign pp_hh = W2'(a_i[XLEN-1:H]) * W2'(b_i[XLEN-1:H]);
         assign prod  = (pp_hh << XLEN) + ((pp_lh + pp_hl) << H) + pp_ll;
      end else begin : g_direct
         assign prod = W2'(a_i) * W2'(b_i);
      end
   endgenerate

   assign sum  = prod + W2'(c_i);
   assign hi_o = sum[W2-1:XLEN];
   assign lo_o = sum[XLEN-1:0];

   // R2
   max_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&hi_o) |-> (lo_o == '0));

endmodule

// File: rtl/vmadd_regfile.sv
module vmadd_regfile #(
   parameter int XLEN   = 64,
   parameter int NREG   = 32,
   parameter int RIDX_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RIDX_W-1:0] a_addr_i,
   input  logic [RIDX_W-1:0] b_addr_i,
   input  logic [RIDX_W-1:0] c_addr_i,
   output logic [XLEN-1:0]   a_data_o,
   output logic [XLEN-1:0]   b_data_o,
   output logic [XLEN-1:0]   c_data_o,
   input  logic              wr_en_i,
   input  logic [RIDX_W-1:0] lo_addr_i,
   input  logic [XLEN-1:0]   lo_data_i,
   input  logic [RIDX_W-1:0] hi_addr_i,
   input  logic [XLEN-1:0]   hi_data_i,
   input  logic [RIDX_W-1:0] dbg_addr_i,
   output logic [XLEN-1:0]   dbg_data_o
);
   import vmadd_pkg::*;

   logic [XLEN-1:0] mem [NREG];

   function automatic logic [XLEN-1:0] seed(input int unsigned idx);
      logic [63:0] t;
      t = 64'(idx) * SEED_MULT;
      return ~XLEN'(t);
   endfunction

   // the high-half write is issued last, so it is kept on a collision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= seed(i);
      end else if (wr_en_i) begin
         mem[lo_addr_i] <= lo_data_i;
         mem[hi_addr_i] <= hi_data_i;
      end
   end

   assign a_data_o   = mem[a_addr_i];
   assign b_data_o   = mem[b_addr_i];
   assign c_data_o   = mem[c_addr_i];
   assign dbg_data_o = mem[dbg_addr_i];

   // R3
   hi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (lo_addr_i == hi_addr_i)) |=>
         (mem[$past(hi_addr_i)] == $past(hi_data_i)));

endmodule

// File: rtl/vmadd_ctrl.sv
module vmadd_ctrl #(
   parameter int NREG   = 32,
   parameter int VL_W   = 6,
   parameter int RIDX_W = $clog2(NREG)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [RIDX_W-1:0]     ra_i,
   input  logic [RIDX_W-1:0]     rb_i,
   input  logic [RIDX_W-1:0]     rc_i,
   input  logic [RIDX_W-1:0]     rt_i,
   input  vmadd_pkg::vec_flags_t flags_i,
   input  vmadd_pkg::hi_dest_e   mode_i,
   input  logic [VL_W-1:0]       vl_i,
   output logic                  busy_o,
   output logic                  done_o,
   output logic [RIDX_W-1:0]     a_addr_o,
   output logic [RIDX_W-1:0]     b_addr_o,
   output logic [RIDX_W-1:0]     c_addr_o,
   output logic [RIDX_W-1:0]     lo_addr_o,
   output logic [RIDX_W-1:0]     hi_addr_o,
   output logic                  wr_en_o
);
   import vmadd_pkg::*;

   logic                busy_q, done_q;
   logic [VL_W-1:0]     idx_q, vl_q;
   logic [RIDX_W-1:0]   ra_q, rb_q, rc_q, rt_q;
   vec_flags_t          flags_q;
   hi_dest_e            mode_q;

   logic                last;
   logic [RIDX_W-1:0]   idx_r, vl_r, rs_base;
   logic                rs_vec;

   assign last = (idx_q == vl_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         idx_q   <= '0;
         vl_q    <= '0;
         ra_q    <= '0;
         rb_q    <= '0;
         rc_q    <= '0;
         rt_q    <= '0;
         flags_q <= '0;
         mode_q  <= HI_ABOVE_RT;
      end else if (!busy_q) begin
         done_q <= 1'b0;
         if (start_i) begin
            ra_q    <= ra_i;
            rb_q    <= rb_i;
            rc_q    <= rc_i;
            rt_q    <= rt_i;
            flags_q <= flags_i;
            mode_q  <= mode_i;
            vl_q    <= vl_i;
            idx_q   <= '0;
            busy_q  <= (vl_i != '0);
            done_q  <= (vl_i == '0);
         end
      end else if (last) begin
         busy_q <= 1'b0;
         done_q <= 1'b1;
      end else begin
         idx_q <= idx_q + 1'b1;
      end
   end

   // element index and count folded onto the register numbering
   generate
      if (VL_W >= RIDX_W) begin : g_fold_trunc
         assign idx_r = idx_q[RIDX_W-1:0];
         assign vl_r  = vl_q[RIDX_W-1:0];
      end else begin : g_fold_ext
         assign idx_r = RIDX_W'(idx_q);
         assign vl_r  = RIDX_W'(vl_q);
      end
   endgenerate

   function automatic logic [RIDX_W-1:0] step(input logic [RIDX_W-1:0] base,
                                               input logic vec,
                                               input logic [RIDX_W-1:0] off);
      return vec ? base + off : base;
   endfunction

   assign rs_base = (mode_q == HI_INTO_ADDEND) ? rc_q : rt_q + vl_r;
   assign rs_vec  = (mode_q == HI_INTO_ADDEND) ? flags_q.c : flags_q.t;

   assign a_addr_o  = step(ra_q, flags_q.a, idx_r);
   assign b_addr_o  = step(rb_q, flags_q.b, idx_r);
   assign c_addr_o  = step(rc_q, flags_q.c, idx_r);
   assign lo_addr_o = step(rt_q, flags_q.t, idx_r);
   assign hi_addr_o = step(rs_base, rs_vec, idx_r);
   assign wr_en_o   = busy_q;
   assign busy_o    = busy_q;
   assign done_o    = done_q;

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R8
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));
   // R8
   busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last) |=> busy_o);
   // R9
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i) |=> ($stable(rt_q) && $stable(vl_q) && $stable(rc_q)));
   // R4
   vec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last && flags_q.t) |=>
         (lo_addr_o == RIDX_W'($past(lo_addr_o) + 1'b1)));
   // R4
   scalar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last && !flags_q.t) |=> $stable(lo_addr_o));

endmodule

// File: rtl/vmadd_engine.sv
module vmadd_engine #(
   parameter int XLEN      = 64,
   parameter int NREG      = 32,
   parameter int VL_W      = 6,
   parameter bit MUL_SPLIT = 1'b1,
   localparam int RIDX_W   = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [RIDX_W-1:0] src_a,
   input  logic [RIDX_W-1:0] src_b,
   input  logic [RIDX_W-1:0] src_c,
   input  logic [RIDX_W-1:0] dst_lo,
   input  logic              vec_a,
   input  logic              vec_b,
   input  logic              vec_c,
   input  logic              vec_lo,
   input  logic              hi_to_addend,
   input  logic [VL_W-1:0]   vl,
   output logic              busy,
   output logic              done,
   input  logic [RIDX_W-1:0] dbg_addr,
   output logic [XLEN-1:0]   dbg_data
);
   import vmadd_pkg::*;

   initial begin : param_chk
      assert (NREG >= 2 && (NREG & (NREG - 1)) == 0)
         else $error("NREG must be a power of two");
      assert (XLEN >= 2 && (XLEN % 2) == 0) else $error("XLEN must be even");
      assert (VL_W >= 1) else $error("VL_W must be positive");
   end

   vec_flags_t        flags;
   hi_dest_e          mode;
   logic [RIDX_W-1:0] a_addr, b_addr, c_addr, lo_addr, hi_addr;
   logic              wr_en;
   logic [XLEN-1:0]   a_data, b_data, c_data, hi_data, lo_data;

   assign flags = '{a: vec_a, b: vec_b, c: vec_c, t: vec_lo};
   assign mode  = hi_to_addend ? HI_INTO_ADDEND : HI_ABOVE_RT;

   vmadd_ctrl #(.NREG(NREG), .VL_W(VL_W), .RIDX_W(RIDX_W)) u_ctrl (
      .clk, .rst_n,
      .start_i(start), .ra_i(src_a), .rb_i(src_b), .rc_i(src_c), .rt_i(dst_lo),
      .flags_i(flags), .mode_i(mode), .vl_i(vl),
      .busy_o(busy), .done_o(done),
      .a_addr_o(a_addr), .b_addr_o(b_addr), .c_addr_o(c_addr),
      .lo_addr_o(lo_addr), .hi_addr_o(hi_addr), .wr_en_o(wr_en)
   );

   vmadd_regfile #(.XLEN(XLEN), .NREG(NREG), .RIDX_W(RIDX_W)) u_rf (
      .clk, .rst_n,
      .a_addr_i(a_addr), .b_addr_i(b_addr), .c_addr_i(c_addr),
      .a_data_o(a_data), .b_data_o(b_data), .c_data_o(c_data),
      .wr_en_i(wr_en),
      .lo_addr_i(lo_addr), .lo_data_i(lo_data),
      .hi_addr_i(hi_addr), .hi_data_i(hi_data),
      .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data)
   );

   vmadd_mul #(.XLEN(XLEN), .SPLIT(MUL_SPLIT)) u_mul (
      .clk, .rst_n,
      .a_i(a_data), .b_i(b_data), .c_i(c_data),
      .hi_o(hi_data), .lo_o(lo_data)
   );

endmodule

// File: tb/vmadd_engine_bench.sv
module vmadd_engine_bench;
   localparam int XLEN = 64;
   localparam int NREG = 16;
   localparam int VL_W = 5;
   localparam int RW   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [RW-1:0] src_a = '0, src_b = '0, src_c = '0, dst_lo = '0, dbg_addr = '0;
   logic vec_a = 0, vec_b = 0, vec_c = 0, vec_lo = 0, hi_to_addend = 0;
   logic [VL_W-1:0] vl = '0;
   logic busy, done;
   logic [XLEN-1:0] dbg_data;

   int checks = 0;
   int errors = 0;
   int cycle  = 0;
   bit mon_en = 1'b0;

   always #10 clk = ~clk;

   vmadd_engine #(.XLEN(XLEN), .NREG(NREG), .VL_W(VL_W), .MUL_SPLIT(1'b1)) u_vmadd_engine (
      .clk, .rst_n, .start, .src_a, .src_b, .src_c, .dst_lo,
      .vec_a, .vec_b, .vec_c, .vec_lo, .hi_to_addend, .vl,
      .busy, .done, .dbg_addr, .dbg_data
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [XLEN-1:0] m_reg [NREG];
   bit m_busy, m_done;
   int m_idx, m_vl;
   int m_a, m_b, m_c, m_t;
   bit m_fa, m_fb, m_fc, m_ft, m_md;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) m_reg[i] = ~(64'(i) * 64'h9E3779B97F4A7C15);
         m_busy = 0; m_done = 0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            int ia, ib, ic, it, is;
            logic [127:0] r;
            ia = (m_a + (m_fa ? m_idx : 0)) % NREG;
            ib = (m_b + (m_fb ? m_idx : 0)) % NREG;
            ic = (m_c + (m_fc ? m_idx : 0)) % NREG;
            it = (m_t + (m_ft ? m_idx : 0)) % NREG;
            if (m_md) is = (m_c + (m_fc ? m_idx : 0)) % NREG;
            else      is = (m_t + m_vl + (m_ft ? m_idx : 0)) % NREG;
            r = {64'd0, m_reg[ia]} * {64'd0, m_reg[ib]} + {64'd0, m_reg[ic]};
            m_reg[it] = r[63:0];
            m_reg[is] = r[127:64];
            if (m_idx == m_vl - 1) begin m_busy = 0; m_done = 1; end
            else m_idx++;
         end else if (start) begin
            m_a = src_a; m_b = src_b; m_c = src_c; m_t = dst_lo;
            m_fa = vec_a; m_fb = vec_b; m_fc = vec_c; m_ft = vec_lo;
            m_md = hi_to_addend; m_vl = vl; m_idx = 0;
            if (vl == 0) m_done = 1; else m_busy = 1;
         end
      end
   end

   // per-clock comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && mon_en) begin
         chk(busy == m_busy, "R8 busy per cycle", busy, m_busy);
         chk(done == m_done, "R8 done per cycle", done, m_done);
         chk(dbg_data == m_reg[dbg_addr], "R10 debug read per cycle",
             dbg_data, m_reg[dbg_addr]);
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycle++;
      if (cycle == 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycle);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic rd_chk(input int addr, input logic [XLEN-1:0] exp, input string tag);
      @(posedge clk); #2;
      dbg_addr = RW'(addr);
      #3;
      chk(dbg_data == exp, tag, dbg_data, exp);
   endtask

   // issue one command, then count busy cycles and check the done pulse
   task automatic run(input int a, b, c, t, input bit fa, fb, fc, ft, md,
                      input int n, input string tag, input bit poke);
      int cnt;
      @(posedge clk); #2;
      src_a = RW'(a); src_b = RW'(b); src_c = RW'(c); dst_lo = RW'(t);
      vec_a = fa; vec_b = fb; vec_c = fc; vec_lo = ft; hi_to_addend = md;
      vl = VL_W'(n); start = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
      cnt = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (busy) cnt++;
         else break;
         if (poke && cnt == 2) begin
            #2; // R9: foreign command while busy
            dst_lo = RW'(3); vl = VL_W'(7); hi_to_addend = 1'b0; start = 1'b1;
            @(posedge clk); #2; start = 1'b0;
         end
      end
      chk(cnt == n, {tag, " R8 busy length"}, cnt, n);
      chk(done == 1'b1, {tag, " R8 done after last element"}, done, 1);
      @(negedge clk);
      chk(done == 1'b0, {tag, " R8 done single cycle"}, done, 0);
   endtask

   initial begin
      logic [XLEN-1:0] keep;
      repeat (3) @(posedge clk);
      #2;
      // R1: reset state
      chk(busy == 1'b0, "R1 busy in reset", busy, 0);
      chk(done == 1'b0, "R1 done in reset", done, 0);
      rst_n = 1'b1;
      for (int i = 0; i < NREG; i++)
         rd_chk(i, ~(64'(i) * 64'h9E3779B97F4A7C15), "R1 reset pattern");
      mon_en = 1'b1;

      // R2: worst case operands, scalar default RS = RT + 1
      run(0, 0, 0, 1, 0, 0, 0, 0, 0, 1, "max", 0);
      rd_chk(1, 64'h0, "R2 max lo");
      rd_chk(2, {64{1'b1}}, "R2 max hi at RT+1 (R5)");

      // R4/R5: vector sources and destination, RS block wraps past the top
      rd_chk(5, m_reg[5], "snapshot");
      keep = dbg_data;
      run(3, 7, 5, 10, 1, 1, 0, 1, 0, 4, "vecabove", 0);
      rd_chk(5, keep, "R5 addend untouched");
      rd_chk(14, m_reg[14], "R4 hi element 0");
      rd_chk(1, m_reg[1], "R4 hi element 3 wrapped");
      rd_chk(13, m_reg[13], "R4 lo element 3");

      // R5 with scalar RT: RS scalar at RT + VL
      run(4, 6, 8, 9, 0, 0, 0, 0, 0, 3, "scalarabove", 0);
      rd_chk(12, m_reg[12], "R5 scalar RS at RT+VL");
      rd_chk(9, m_reg[9], "R5 scalar RT last lo");

      // R6: carry chain through scalar addend
      run(4, 8, 2, 12, 1, 1, 0, 1, 1, 3, "chain", 0);
      rd_chk(2, m_reg[2], "R6 running carry in addend");
      rd_chk(14, m_reg[14], "R6 lo of last element");

      // R7 + R9: vector accumulator, with a start while busy
      run(5, 9, 0, 11, 1, 0, 1, 1, 1, 5, "accum", 1);
      for (int i = 0; i < 5; i++) rd_chk(i, m_reg[i], "R7 accumulator element");

      // R3: RT and RS collide, hi kept
      run(6, 7, 9, 9, 0, 0, 0, 0, 1, 1, "collide", 0);
      rd_chk(9, m_reg[9], "R3 hi wins on collision");

      // R8: empty command
      rd_chk(0, m_reg[0], "snapshot");
      keep = dbg_data;
      run(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, "empty", 0);
      rd_chk(0, keep, "R8 vl zero writes nothing");

      // R10: final sweep of the whole file
      for (int i = 0; i < NREG; i++) rd_chk(i, m_reg[i], "R10 final contents");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule